// File: doc/BRIEF.md
# Cold Boot Warm-Up Controller

This block decides, once per reset, whether the system warms up before it powers up normally. It is enabled by a nonzero pin-selection byte. When reset is released it samples a thermal-state input. If the input is deasserted, meaning the board is too cold, the block enters a warm-up mode. In that mode only the rails that do not depend on the thermal input may come up, and the system watchdog is held off. If the input is asserted, or the mode is disabled, the block goes straight to normal operation.

Warm-up ends when the thermal input asserts, or when a timeout counted in minutes expires. From then on the thermal input is reported as asserted through an override flag. Every warm-up rail that has an enable pin is forced off. The block waits until all of those rails report power-good-off, counts a start delay in millisecond ticks, and then releases normal power-up. It stays in normal operation until the next reset.

All pins are plain control and status levels sampled on the clock. None of them is a data stream, so no valid/ready handshake and no back-pressure apply. A 1 ms tick pulse drives all timing. Minutes are derived from it by a prescaler.

Top module: `coldboot_warmup_ctrl`

## Requirements
- R1: When `mode_pin_sel` is zero the block enters normal operation on the first clock after reset, whatever the level of `thermal_in`. In that case `wdog_suppress`, `fault_log` and `thermal_ovr` stay 0 and `normal_go` becomes 1.
- R2: With the mode enabled, `thermal_in` is sampled on the first clock after reset. A value of 0 (deasserted) enters warm-up and a value of 1 enters normal operation. A later change of `thermal_in` never brings warm-up back before the next reset.
- R3: `fault_log` pulses for exactly one cycle, the cycle in which warm-up begins, and only when `log_en` is 1. No other event raises it.
- R4: `wdog_suppress` is 1 in every cycle of warm-up and 0 in every other cycle.
- R5: While in warm-up, `thermal_in` = 1 ends warm-up on the next clock. `thermal_ovr` then rises and stays 1 until reset, and later values of `thermal_in` have no effect.
- R6: With `cold_timeout_min` = T > 0, warm-up ends on the clock after the (T×MS_PER_MIN)-th `ms_tick` pulse counted in warm-up. With T = 0 it never times out.
- R7: When warm-up ends, `force_off` becomes `cold_rail_mask & rail_has_en` on the same clock that ends warm-up. Bit i of each mask belongs to rail i.
- R8: The start delay does not begin until every rail set in `force_off` shows `rail_pgoff` = 1. The block then counts `start_delay_ms` tick pulses, or none when that value is 0. On the following clock it sets `normal_go` and clears `force_off`.
- R9: Once `normal_go` is 1 it stays 1, with `wdog_suppress` at 0, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| thermal_in | input | 1 | Thermal state, 1 = asserted (warm enough) |
| mode_pin_sel | input | 8 | Warm-up pin selection, zero disables the mode |
| log_en | input | 1 | Allows the fault-log strobe |
| cold_timeout_min | input | TO_W | Warm-up timeout in minutes, 0 = none |
| start_delay_ms | input | DLY_W | Delay in ms ticks before normal release |
| cold_rail_mask | input | N_RAILS | Rails that run during warm-up |
| rail_has_en | input | N_RAILS | Rails with an enable pin |
| rail_pgoff | input | N_RAILS | Per-rail below power-good-off flag |
| force_off | output | N_RAILS | Rails forced off after warm-up |
| thermal_ovr | output | 1 | Thermal input treated as asserted |
| wdog_suppress | output | 1 | Holds off the system watchdog |
| fault_log | output | 1 | One-cycle fault-log strobe |
| normal_go | output | 1 | Normal power-up released |

## Verification
The boot decision and the log strobe are due on the first rising edge after reset is released. The end of warm-up, the override flag and the force-off mask are due one edge after the edge that samples thermal assertion or the final tick. With all forced rails already off, release comes three edges later when the delay is zero. With a nonzero delay, release comes one edge after the edge that counts the last delay tick. The bench drives and samples one time unit after each rising edge and advances a counted number of edges before each check. It checks the cycle just before each transition as well as the cycle the transition is due, so a result one cycle early or late is caught.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  typedef enum logic [2:0] {
    ST_RESET_SAMPLE = 3'd0,
    ST_COLD         = 3'd1,
    ST_SHUTDOWN     = 3'd2,
    ST_WAIT_PGOFF   = 3'd3,
    ST_START_DELAY  = 3'd4,
    ST_NORMAL       = 3'd5
  } cbw_state_e;
endpackage

// File: rtl/cbw_minute_prescaler.sv
module cbw_minute_prescaler #(
  parameter int MS_PER_MIN = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ms_tick,
  output logic min_tick
);
  localparam int W = (MS_PER_MIN > 2) ? $clog2(MS_PER_MIN) : 1;
  localparam logic [W-1:0] LAST = W'(MS_PER_MIN - 1);

  logic [W-1:0] div_q;

  assign min_tick = run && ms_tick && (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (!run)       div_q <= '0;
    else if (min_tick)   div_q <= '0;
    else if (ms_tick)    div_q <= div_q + 1'b1;
  end

  // R6: a minute boundary only ever coincides with a millisecond tick
  p_min_on_ms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    min_tick |-> ms_tick);
  // R6: divider never passes its terminal count
  p_div_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST);
endmodule

// File: rtl/cbw_pulse_count.sv
module cbw_pulse_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  // R6: while counting, the value only climbs and by at most one
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/coldboot_warmup_ctrl.sv
module coldboot_warmup_ctrl
  import cbw_pkg::*;
#(
  parameter int N_RAILS    = 16,
  parameter int MS_PER_MIN = 60000,
  parameter int TO_W       = 8,
  parameter int DLY_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick,
  input  logic               thermal_in,
  input  logic [7:0]         mode_pin_sel,
  input  logic               log_en,
  input  logic [TO_W-1:0]    cold_timeout_min,
  input  logic [DLY_W-1:0]   start_delay_ms,
  input  logic [N_RAILS-1:0] cold_rail_mask,
  input  logic [N_RAILS-1:0] rail_has_en,
  input  logic [N_RAILS-1:0] rail_pgoff,
  output logic [N_RAILS-1:0] force_off,
  output logic               thermal_ovr,
  output logic               wdog_suppress,
  output logic               fault_log,
  output logic               normal_go
);
  cbw_state_e         st_q, st_d;
  logic [N_RAILS-1:0] force_q;
  logic               ovr_q, log_q;
  logic               min_tick;
  logic [TO_W-1:0]    min_cnt;
  logic [DLY_W-1:0]   dly_cnt;
  logic               in_cold, in_delay;
  logic               timed_out, cold_done, pg_done, dly_done, enter_cold;

  assign in_cold  = (st_q == ST_COLD);
  assign in_delay = (st_q == ST_START_DELAY);

  cbw_minute_prescaler #(.MS_PER_MIN(MS_PER_MIN)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(in_cold), .ms_tick(ms_tick), .min_tick(min_tick)
  );

  cbw_pulse_count #(.W(TO_W)) u_min_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_cold), .inc(min_tick), .cnt(min_cnt)
  );

  cbw_pulse_count #(.W(DLY_W)) u_dly_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!in_delay), .inc(ms_tick), .cnt(dly_cnt)
  );

  assign timed_out  = (cold_timeout_min != '0) && (min_cnt >= cold_timeout_min);
  assign cold_done  = thermal_in || timed_out;
  assign pg_done    = ((force_q & ~rail_pgoff) == '0);
  assign dly_done   = (dly_cnt >= start_delay_ms);
  assign enter_cold = (st_q == ST_RESET_SAMPLE) && (mode_pin_sel != 8'd0) && !thermal_in;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET_SAMPLE: st_d = enter_cold ? ST_COLD : ST_NORMAL;
      ST_COLD:         if (cold_done) st_d = ST_SHUTDOWN;
      ST_SHUTDOWN:     st_d = ST_WAIT_PGOFF;
      ST_WAIT_PGOFF:   if (pg_done) st_d = ST_START_DELAY;
      ST_START_DELAY:  if (dly_done) st_d = ST_NORMAL;
      ST_NORMAL:       st_d = ST_NORMAL;
      default:         st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RESET_SAMPLE;
      force_q <= '0;
      ovr_q   <= 1'b0;
      log_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      log_q <= enter_cold && log_en;
      if (in_cold && cold_done) begin
        force_q <= cold_rail_mask & rail_has_en;
        ovr_q   <= 1'b1;
      end else if (in_delay && dly_done) begin
        force_q <= '0;
      end
    end
  end

  assign force_off     = force_q;
  assign thermal_ovr   = ovr_q;
  assign wdog_suppress = in_cold;
  assign fault_log     = log_q;
  assign normal_go     = (st_q == ST_NORMAL);

  // R9: normal operation is final until reset
  p_normal_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    normal_go |=> normal_go);
  // R5: the override never drops once set
  p_ovr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_ovr |=> thermal_ovr);
  // R4: watchdog hold-off and override never coexist
  p_wdog_cold_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_suppress |-> !thermal_ovr && !normal_go);
  // R3: the log strobe is a single cycle at the start of warm-up
  p_log_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_log |=> !fault_log);
  p_log_in_cold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_log |-> wdog_suppress);
  // R7: forced mask taken from the enable-pin warm-up rails
  p_force_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thermal_ovr) |-> force_off == $past(cold_rail_mask & rail_has_en));
  // R8: no progress while a forced rail is still above power-good-off
  p_wait_pgoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_PGOFF) && ((force_off & ~rail_pgoff) != '0) |=> (st_q == ST_WAIT_PGOFF));
  // R1: a disabled mode never enters warm-up
  p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RESET_SAMPLE) && (mode_pin_sel == 8'd0) |=> normal_go);
endmodule

// File: tb/sim_coldboot_warmup_ctrl.sv
module sim_coldboot_warmup_ctrl;
  localparam int N = 4;
  localparam int MPM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, thermal_in = 1'b0, log_en = 1'b0;
  logic [7:0] mode_pin_sel = 8'd0;
  logic [7:0] cold_timeout_min = 8'd0, start_delay_ms = 8'd0;
  logic [N-1:0] cold_rail_mask = '0, rail_has_en = '0, rail_pgoff = '0;
  logic [N-1:0] force_off;
  logic thermal_ovr, wdog_suppress, fault_log, normal_go;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coldboot_warmup_ctrl #(.N_RAILS(N), .MS_PER_MIN(MPM), .TO_W(8), .DLY_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .thermal_in(thermal_in),
    .mode_pin_sel(mode_pin_sel), .log_en(log_en), .cold_timeout_min(cold_timeout_min),
    .start_delay_ms(start_delay_ms), .cold_rail_mask(cold_rail_mask),
    .rail_has_en(rail_has_en), .rail_pgoff(rail_pgoff), .force_off(force_off),
    .thermal_ovr(thermal_ovr), .wdog_suppress(wdog_suppress), .fault_log(fault_log),
    .normal_go(normal_go)
  );

  // {mode enabled, thermal at boot, log_en, expect warm-up, expect log strobe}
  localparam logic [4:0] BOOT_TBL [5] = '{
    5'b10111, 5'b10010, 5'b11100, 5'b00100, 5'b01000
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      step(1);
      ms_tick = 1'b0;
    end
  endtask

  task automatic boot(input logic en, input logic th, input logic lg);
    rst_n = 1'b0;
    step(2);
    mode_pin_sel = en ? 8'd3 : 8'd0;
    thermal_in = th;
    log_en = lg;
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(2);
    chk("reset wdog", {31'd0, wdog_suppress}, 0);
    chk("reset normal", {31'd0, normal_go}, 0);
    chk("reset force", {28'd0, force_off}, 0);
    chk("reset ovr", {31'd0, thermal_ovr}, 0);

    // Boot decision table: R1 R2 R3 R4
    for (int k = 0; k < 5; k++) begin
      boot(BOOT_TBL[k][4], BOOT_TBL[k][3], BOOT_TBL[k][2]);
      chk("R2 R4 wdog at boot", {31'd0, wdog_suppress}, {31'd0, BOOT_TBL[k][1]});
      chk("R1 R2 normal at boot", {31'd0, normal_go}, {31'd0, !BOOT_TBL[k][1]});
      chk("R3 log strobe", {31'd0, fault_log}, {31'd0, BOOT_TBL[k][0]});
      step(1);
      chk("R3 strobe one cycle", {31'd0, fault_log}, 0);
      chk("R1 ovr stays low", {31'd0, thermal_ovr}, 0);
    end

    // R2: normal boot, later thermal drop does not start warm-up
    boot(1'b1, 1'b1, 1'b1);
    thermal_in = 1'b0;
    step(5);
    chk("R2 no late warm-up", {31'd0, wdog_suppress}, 0);
    chk("R9 stays normal", {31'd0, normal_go}, 1);
    chk("R3 no late log", {31'd0, fault_log}, 0);

    // R5 R7 R8: end by thermal, delay 3
    cold_rail_mask = 4'b0111;
    rail_has_en = 4'b0101;
    rail_pgoff = 4'b0000;
    start_delay_ms = 8'd3;
    cold_timeout_min = 8'd0;
    boot(1'b1, 1'b0, 1'b1);
    chk("R4 wdog in warm-up", {31'd0, wdog_suppress}, 1);
    tick(3);
    chk("R6 zero timeout holds", {31'd0, wdog_suppress}, 1);
    thermal_in = 1'b1;
    step(1);
    chk("R5 ovr rises", {31'd0, thermal_ovr}, 1);
    chk("R7 force mask", {28'd0, force_off}, 32'h5);
    chk("R4 wdog released", {31'd0, wdog_suppress}, 0);
    thermal_in = 1'b0;
    rail_pgoff = 4'b0100;
    step(4);
    chk("R8 wait for pgoff", {31'd0, normal_go}, 0);
    chk("R5 ovr ignores input", {31'd0, thermal_ovr}, 1);
    chk("R4 no re-entry", {31'd0, wdog_suppress}, 0);
    rail_pgoff = 4'b0101;
    step(2);
    tick(2);
    chk("R8 delay not done", {31'd0, normal_go}, 0);
    tick(1);
    chk("R8 last delay tick", {31'd0, normal_go}, 0);
    step(1);
    chk("R8 release", {31'd0, normal_go}, 1);
    chk("R8 force cleared", {28'd0, force_off}, 0);
    thermal_in = 1'b1;
    step(3);
    thermal_in = 1'b0;
    step(3);
    chk("R9 normal sticky", {31'd0, normal_go}, 1);
    chk("R9 wdog low", {31'd0, wdog_suppress}, 0);

    // R6: timeout of 2 minutes, zero delay, rails already off
    cold_timeout_min = 8'd2;
    start_delay_ms = 8'd0;
    rail_pgoff = 4'b1111;
    cold_rail_mask = 4'b1010;
    rail_has_en = 4'b1110;
    boot(1'b1, 1'b0, 1'b0);
    chk("R3 no strobe without log_en", {31'd0, fault_log}, 0);
    tick(2 * MPM - 1);
    chk("R6 before timeout", {31'd0, wdog_suppress}, 1);
    tick(1);
    chk("R6 final tick", {31'd0, wdog_suppress}, 1);
    step(1);
    chk("R6 timed out", {31'd0, wdog_suppress}, 0);
    chk("R7 mask on timeout", {28'd0, force_off}, 32'hA);
    chk("R5 ovr on timeout", {31'd0, thermal_ovr}, 1);
    step(2);
    chk("R8 zero delay pending", {31'd0, normal_go}, 0);
    step(1);
    chk("R8 zero delay release", {31'd0, normal_go}, 1);

    finish_run();
  end
endmodule